// File: doc/BRIEF.md
# Deferred Exception Token Tracker

This block holds one poison bit per architectural register so that loads hoisted above a branch can fault silently. A speculative load that hits an exception does not trap; it leaves the poison bit of its destination set. Every later operation that reads a poisoned register passes the poison on to the register it writes. A check operation tests the poison bit of one register: when the bit is set it asks the front end to redirect to a supplied recovery address, otherwise execution falls through.

Operations arrive one per clock as small descriptors: a valid bit, a kind code, two source indices, a destination index, a fault flag for the load and a recovery address. Results (redirect request, redirect target, immediate fault) are registered and appear one clock after the operation is presented. A poison bit written by one operation is seen by the operation presented in the next cycle. Register 0 never carries poison. A flush input cancels the operation presented in the same cycle and leaves every bit already written untouched.

Top module: `spec_token_tracker`

## Requirements
- R1: After reset every poison bit is clear and `redirect`, `redirect_pc` and `hard_fault` are 0.
- R2: A speculative load (kind 2) writes its destination poison bit to the OR of the `ld_fault` flag and the poison of `src_a` (its address register), and never raises `hard_fault`.
- R3: An ALU operation (kind 1) writes its destination poison bit to the OR of the poison bits of `src_a` and `src_b`; with both clear the destination becomes clear.
- R4: A non-speculative load (kind 3) clears its destination poison bit whatever `ld_fault` and the source poison are.
- R5: A check (kind 6) whose `src_a` is poisoned sets `redirect` to 1 and `redirect_pc` to `recover_pc` in the next cycle; with `src_a` clear both are 0 in the next cycle.
- R6: A store (kind 4) with `src_a` or `src_b` poisoned, or a branch (kind 5) with `src_a` poisoned, sets `hard_fault` in the next cycle; otherwise `hard_fault` is 0.
- R7: Register 0 always reads as clear and writes to it are ignored.
- R8: With `flush` high the operation presented in that cycle writes no poison bit and produces no redirect or fault; bits written earlier keep their values.
- R9: With `op_valid` low, or kind 0 or 7, no poison bit changes and all outputs are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_kind | input | 3 | 0 none, 1 ALU, 2 speculative load, 3 load, 4 store, 5 branch, 6 check, 7 none |
| src_a | input | IDX_W | First source register index |
| src_b | input | IDX_W | Second source register index |
| dst | input | IDX_W | Destination register index |
| ld_fault | input | 1 | The load of this operation met an exception |
| recover_pc | input | ADDR_W | Recovery address for a check |
| flush | input | 1 | Cancel the operation of this cycle |
| redirect | output | 1 | Check found poison (one cycle late) |
| redirect_pc | output | ADDR_W | Recovery address when `redirect` is 1, else 0 |
| hard_fault | output | 1 | Store or branch consumed poison |

## Verification
Two functions meet in one cycle when a flush lands on a poisoning load or on a check of a poisoned register: the write and the redirect must both be suppressed. The bench provokes this directly and then issues an ordinary check of the same register, judging that the poison seen afterwards is the value from before the flushed operation. A second overlap is an ALU operation that reads and writes the same register, which must use the old bit; the exhaustive source/destination sweep covers it and each result is judged by a following check against a bench-side poison model.

// File: rtl/spec_token_tracker.sv
module spec_token_tracker #(
  parameter int NREGS  = 128,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  input  logic [IDX_W-1:0]  dst,
  input  logic              ld_fault,
  input  logic [ADDR_W-1:0] recover_pc,
  input  logic              flush,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              hard_fault
);
  localparam logic [2:0] K_ALU = 3'd1, K_SLD = 3'd2, K_LD = 3'd3,
                         K_ST  = 3'd4, K_BR  = 3'd5, K_CHK = 3'd6;

  logic [NREGS-1:0] tok_q;
  logic live, pa, pb, wr_en, wr_val;

  assign live = op_valid && !flush;
  assign pa   = (src_a != '0) && tok_q[src_a];
  assign pb   = (src_b != '0) && tok_q[src_b];

  always_comb begin
    wr_en  = 1'b0;
    wr_val = 1'b0;
    case (op_kind)
      K_ALU: begin wr_en = 1'b1; wr_val = pa | pb;       end
      K_SLD: begin wr_en = 1'b1; wr_val = ld_fault | pa; end
      K_LD:  begin wr_en = 1'b1; wr_val = 1'b0;          end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tok_q <= '0;
    else if (live && wr_en && dst != '0)
      tok_q[dst] <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      hard_fault  <= 1'b0;
    end else begin
      redirect    <= live && op_kind == K_CHK && pa;
      redirect_pc <= (live && op_kind == K_CHK && pa) ? recover_pc : '0;
      hard_fault  <= live && ((op_kind == K_ST && (pa || pb)) ||
                              (op_kind == K_BR && pa));
    end
  end
endmodule

module spec_token_tracker_chk #(
  parameter int NREGS = 128,
  parameter int ADDR_W = 32,
  parameter int IDX_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_kind,
  input logic [IDX_W-1:0]  dst,
  input logic              ld_fault,
  input logic              flush,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic              hard_fault,
  input logic [NREGS-1:0]  tok_q
);
  // R7
  reg_zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !tok_q[0]);
  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !redirect && !hard_fault && $stable(tok_q));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !redirect && !hard_fault && $stable(tok_q));
  // R4
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flush && op_kind == 3'd3 |=> !tok_q[$past(dst)]);
  // R2
  spec_fault_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flush && op_kind == 3'd2 && ld_fault && dst != '0
    |=> tok_q[$past(dst)] && !hard_fault);
  // R5
  redirect_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> redirect_pc == '0);
  // R6
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect, hard_fault}));
endmodule

bind spec_token_tracker spec_token_tracker_chk #(.NREGS(NREGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .dst(dst),
  .ld_fault(ld_fault), .flush(flush), .redirect(redirect), .redirect_pc(redirect_pc),
  .hard_fault(hard_fault), .tok_q(tok_q));

// File: tb/spec_token_tracker_test.sv
module spec_token_tracker_test;
  localparam int PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0, op_valid = 0, ld_fault = 0, flush = 0;
  logic [2:0] op_kind = 0;
  logic [IW-1:0] src_a = 0, src_b = 0, dst = 0;
  logic [31:0] recover_pc = 0, redirect_pc;
  logic redirect, hard_fault;
  int runs = 0, fails = 0;
  bit model [N];

  always #(PERIOD/2) clk = ~clk;

  spec_token_tracker #(.NREGS(N), .ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .src_a(src_a),
    .src_b(src_b), .dst(dst), .ld_fault(ld_fault), .recover_pc(recover_pc), .flush(flush),
    .redirect(redirect), .redirect_pc(redirect_pc), .hard_fault(hard_fault));

  task automatic check_out(input string req, input bit er, input logic [31:0] et, input bit ef);
    runs++;
    if (redirect !== er || redirect_pc !== et || hard_fault !== ef) begin
      fails++;
      $display("FAIL %s: got redirect=%0b pc=%h fault=%0b, expected redirect=%0b pc=%h fault=%0b",
               req, redirect, redirect_pc, hard_fault, er, et, ef);
    end
  endtask

  task automatic op(input string req, input bit v, input logic [2:0] k, input int a, input int b,
                    input int d, input bit flt, input logic [31:0] ra, input bit fl);
    bit ta, tb, er, ef;
    logic [31:0] et;
    ta = (a == 0) ? 1'b0 : model[a];
    tb = (b == 0) ? 1'b0 : model[b];
    er = 0; ef = 0; et = 0;
    if (v && !fl) begin
      case (k)
        3'd1: if (d != 0) model[d] = ta | tb;
        3'd2: if (d != 0) model[d] = flt | ta;
        3'd3: if (d != 0) model[d] = 1'b0;
        3'd4: ef = ta | tb;
        3'd5: ef = ta;
        3'd6: begin er = ta; et = ta ? ra : 32'd0; end
        default: ;
      endcase
    end
    @(negedge clk);
    op_valid = v; op_kind = k; src_a = a[IW-1:0]; src_b = b[IW-1:0]; dst = d[IW-1:0];
    ld_fault = flt; recover_pc = ra; flush = fl;
    @(posedge clk); #1;
    check_out(req, er, et, ef);
  endtask

  task automatic chk(input string req, input int r);
    op(req, 1, 3'd6, r, 0, 0, 0, 32'h1000_0000 + r * 16, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    #(PERIOD * 2 + 2);
    check_out("R1", 0, 0, 0);
    rst_n = 1;
    for (int r = 0; r < N; r++) chk("R1", r);

    for (int p = 0; p < 256; p++) begin
      for (int r = 1; r < N; r++) op("R2", 1, 3'd2, 0, 0, r, p[r], 0, 0);
      op("R7", 1, 3'd2, 0, 0, 0, 1, 0, 0);
      chk("R7", 0);
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++) begin
          op("R6", 1, 3'd4, a, b, 0, 0, 0, 0);
          op("R6", 1, 3'd5, a, b, 0, 0, 0, 0);
          op("R3", 1, 3'd1, a, b, (a + b + p) % N, 0, 0, 0);
          chk("R3", (a + b + p) % N);
        end
    end

    op("R2", 1, 3'd2, 0, 0, 3, 1, 0, 0);
    op("R2", 1, 3'd2, 3, 0, 4, 0, 0, 0);
    chk("R2", 4);
    op("R4", 1, 3'd3, 3, 3, 4, 1, 0, 0);
    chk("R4", 4);
    op("R5", 1, 3'd6, 3, 0, 0, 0, 32'hDEAD_BEE0, 0);
    op("R5", 1, 3'd6, 4, 0, 0, 0, 32'hDEAD_BEE0, 0);
    op("R8", 1, 3'd2, 0, 0, 5, 1, 0, 1);
    op("R8", 1, 3'd3, 0, 0, 3, 0, 0, 1);
    op("R8", 1, 3'd6, 3, 0, 0, 0, 32'h55, 1);
    op("R8", 1, 3'd4, 3, 3, 0, 0, 0, 1);
    chk("R8", 5);
    chk("R8", 3);
    op("R9", 0, 3'd6, 3, 0, 0, 0, 32'h77, 0);
    op("R9", 0, 3'd2, 0, 0, 6, 1, 0, 0);
    op("R9", 1, 3'd7, 3, 3, 6, 1, 0, 0);
    op("R9", 1, 3'd0, 3, 3, 3, 1, 0, 0);
    chk("R9", 6);
    chk("R9", 3);
    op("R7", 1, 3'd1, 3, 3, 0, 0, 0, 0);
    chk("R7", 0);
    op("R7", 1, 3'd1, 0, 0, 3, 0, 0, 0);
    chk("R7", 3);

    @(negedge clk);
    op_valid = 0; flush = 0;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule